// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides whether a phase-locked loop has settled on its target frequency. It counts rising edges of the divided VCO feedback clock over a measurement window of a fixed number of reference-clock cycles. It then compares that count with the count expected from the programmed multiplier. Every window ends with a verdict, so the block reaches a decision faster when the reference clock is faster.

From each verdict the block picks the loop-filter mode. A large error selects acquisition, which allows wide frequency corrections. A small error, seen for enough windows in a row, selects tracking, which allows only fine corrections. The same verdict drives a lock status bit and a "safe to switch the base clock to the PLL" indication. Any change in lock sets a sticky event flag, which can raise an interrupt request. When automatic control is off, a software mode bit drives the filter. Lock detection keeps running in that case.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `lock`, `lock_flag`, `irq` and `clk_safe` are 0 and `filt_track` is 0 (acquisition), for as long as the feedback frequency has not been judged.
- R2: A measurement window lasts exactly `WIN_CYCLES` reference cycles (default 64). The expected feedback edge count per window is `mult * WIN_CYCLES`.
- R3: At the end of any window whose count differs from the expected count by more than expected/8, the detector enters acquisition and clears `lock`.
- R4: When the error is at most expected/64 in two consecutive windows, the detector enters tracking and sets `lock` at the end of the second window. It never does so after only one such window.
- R5: An error above expected/64 but not above expected/8 leaves `lock` and the detector mode unchanged, and restarts the count of consecutive good windows.
- R6: `filt_track` is 1 for tracking and 0 for acquisition. With `auto_en`=1 it follows the detector, which is tracking exactly when `lock`=1. With `auto_en`=0 it equals `track_sw`, and `lock` keeps following the detector.
- R7: `lock_flag` becomes 1 on the reference edge after any change of `lock` and stays 1. Holding `flag_clr`=1 for one reference edge clears it, unless a new lock change arrives in the same cycle.
- R8: `irq` is 1 exactly when `lock_flag`=1 and `irq_en`=1.
- R9: `clk_safe` is 1 only while `lock`=1 and `auto_en`=1.
- R10: The feedback edge count reaches the reference domain as a Gray code that changes at most one bit per feedback edge. The count therefore stays correct when the feedback clock runs several times faster than the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; paces the windows and all control logic |
| fb_clk | input | 1 | Divided VCO feedback clock whose edges are counted |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| auto_en | input | 1 | 1: detector chooses the filter mode; 0: `track_sw` chooses |
| track_sw | input | 1 | Manual mode bit: 1 tracking, 0 acquisition |
| irq_en | input | 1 | Enables `irq` from the lock event flag |
| flag_clr | input | 1 | Write-one-to-clear strobe for `lock_flag` |
| mult | input | MULT_W | Multiplier; expected feedback edges per reference cycle |
| filt_track | output | 1 | Filter mode to the loop filter, also the readable mode bit (1 tracking) |
| lock | output | 1 | Lock status |
| lock_flag | output | 1 | Sticky lock-change event flag |
| irq | output | 1 | Lock-change interrupt request |
| clk_safe | output | 1 | PLL output may be selected as base clock |

## Verification
The detector is driven with feedback frequencies that are exact for several multipliers (2, 4, 5, 8), frequencies far off target, and frequencies in the band between the two thresholds. The exact and far-off cases separate the lock and acquisition decisions. The middle band, entered both from a locked and from an unlocked state, shows whether state is held rather than changed. Timed switches between good and bad frequencies measure how many windows a decision takes, which separates the two-window lock rule from a one-window one. Flag, interrupt and manual-mode toggles with lock held steady show that each control acts only on its own output.

// File: rtl/pll_lock_pkg.sv
// Shared types for the PLL lock detector.
package pll_lock_pkg;

    // Loop-filter operating mode; the encoding is the value seen on filt_track.
    typedef enum logic {
        MODE_ACQ   = 1'b0,
        MODE_TRACK = 1'b1
    } filt_mode_e;

endpackage

// File: rtl/fb_gray_counter.sv
// Free-running counter of feedback clock edges, published in Gray code.
// Assumes: rst_n is held across several fb_clk edges; the counter wraps and
// the consumer only ever uses differences between snapshots.
module fb_gray_counter #(
    parameter int CNT_W = 12
) (
    input  logic             fb_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_q
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Count every feedback edge and register its Gray image for crossing.
    always_ff @(posedge fb_clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    // R10: the crossing word never moves by more than one bit per edge.
    p_gray_step_r10: assert property (@(posedge fb_clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/gray_sync.sv
// Two-flop synchronizer for a Gray-coded count, with conversion back to binary.
// Assumes: the source changes at most one bit per source clock edge.
module gray_sync #(
    parameter int CNT_W = 12
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);

    logic [CNT_W-1:0] meta_q;
    logic [CNT_W-1:0] stable_q;

    // Re-time the Gray word into the reference domain through two stages.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= gray_in;
            stable_q <= meta_q;
        end
    end

    // Convert Gray to binary: each bit is the parity of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            bin_out[i] = ^(stable_q >> i);
        end
    end

endmodule

// File: rtl/window_judge.sv
// Paces measurement windows on the reference clock, measures the feedback
// edges seen in each window and decides lock / filter mode.
// Assumes: fb_cnt is a wrapping binary count already in the reference domain,
// and fewer than 2**CNT_W feedback edges occur per window.
module window_judge
    import pll_lock_pkg::*;
#(
    parameter int WIN_CYCLES   = 64,
    parameter int MULT_W       = 4,
    parameter int CNT_W        = 12,
    parameter int ACQ_SHIFT    = 3,
    parameter int LOCK_SHIFT   = 6,
    parameter int LOCK_WINDOWS = 2
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [MULT_W-1:0] mult,
    input  logic [CNT_W-1:0]  fb_cnt,
    output filt_mode_e        det_mode,
    output logic              lock_q
);

    localparam int WIN_W  = $clog2(WIN_CYCLES);
    localparam int GOOD_W = $clog2(LOCK_WINDOWS + 1);

    logic [WIN_W-1:0]  win_cnt_q;
    logic              win_end;
    logic [CNT_W-1:0]  prev_q;
    logic [CNT_W-1:0]  delta;
    logic [CNT_W-1:0]  exp_cnt;
    logic [CNT_W-1:0]  err;
    logic              err_big;
    logic              err_tight;
    logic [GOOD_W-1:0] good_q;

    assign win_end = (win_cnt_q == WIN_W'(WIN_CYCLES - 1));
    assign exp_cnt = CNT_W'(32'(mult) * WIN_CYCLES);
    assign delta   = fb_cnt - prev_q;

    // Absolute difference between measured and expected edge counts.
    always_comb begin
        if (delta >= exp_cnt) err = delta - exp_cnt;
        else                  err = exp_cnt - delta;
    end

    assign err_big   = err > (exp_cnt >> ACQ_SHIFT);
    assign err_tight = err <= (exp_cnt >> LOCK_SHIFT);

    // Window pacing counter, wrapping every WIN_CYCLES reference cycles.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)       win_cnt_q <= '0;
        else if (win_end) win_cnt_q <= '0;
        else              win_cnt_q <= win_cnt_q + 1'b1;
    end

    // Per-window verdict: snapshot the count, then update lock and the good-run count.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            good_q <= '0;
            lock_q <= 1'b0;
        end else if (win_end) begin
            prev_q <= fb_cnt;
            if (err_big) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end else if (err_tight) begin
                if (good_q >= GOOD_W'(LOCK_WINDOWS - 1)) lock_q <= 1'b1;
                else                                    good_q <= good_q + 1'b1;
            end else begin
                good_q <= '0;
            end
        end
    end

    assign det_mode = lock_q ? MODE_TRACK : MODE_ACQ;

    // R2: the window counter stays inside its window.
    p_win_bound_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        {1'b0, win_cnt_q} < (WIN_W + 1)'(WIN_CYCLES));

    // R4: lock is only ever gained at a window boundary.
    p_lock_rise_window_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(win_end));

    // R3: lock is only ever lost at a window boundary.
    p_lock_fall_window_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(win_end));

endmodule

// File: rtl/lock_event_irq.sv
// Sticky lock-change flag with write-one-to-clear and an enabled interrupt request.
// Assumes: flag_clr is a one-cycle strobe in the reference domain.
module lock_event_irq (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic lock,
    input  logic irq_en,
    input  logic flag_clr,
    output logic lock_flag,
    output logic irq
);

    logic lock_d_q;

    // Remember last cycle's lock so a change can be seen.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) lock_d_q <= 1'b0;
        else        lock_d_q <= lock;
    end

    // Set on a lock change (priority), clear on the strobe, otherwise hold.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                lock_flag <= 1'b0;
        else if (lock != lock_d_q) lock_flag <= 1'b1;
        else if (flag_clr)         lock_flag <= 1'b0;
    end

    assign irq = lock_flag & irq_en;

    // R7: every lock change leaves the flag raised on the next cycle.
    p_flag_on_change_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lock != lock_d_q) |=> lock_flag);

    // R7: a clear strobe with no concurrent change empties the flag.
    p_flag_clear_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (flag_clr && (lock == lock_d_q)) |=> !lock_flag);

endmodule

// File: rtl/pll_lock_detect.sv
// Top of the PLL frequency lock detector: feedback edge counting in the
// feedback domain, Gray crossing, window verdicts, mode selection and events.
// Assumes: rst_n is synchronous to ref_clk and held long enough to be seen
// by several edges of both clocks.
module pll_lock_detect
    import pll_lock_pkg::*;
#(
    parameter int WIN_CYCLES   = 64,
    parameter int MULT_W       = 4,
    parameter int ACQ_SHIFT    = 3,
    parameter int LOCK_SHIFT   = 6,
    parameter int LOCK_WINDOWS = 2
) (
    input  logic              ref_clk,
    input  logic              fb_clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic              track_sw,
    input  logic              irq_en,
    input  logic              flag_clr,
    input  logic [MULT_W-1:0] mult,
    output logic              filt_track,
    output logic              lock,
    output logic              lock_flag,
    output logic              irq,
    output logic              clk_safe
);

    localparam int CNT_W = MULT_W + $clog2(WIN_CYCLES) + 2;

    logic [CNT_W-1:0] fb_gray;
    logic [CNT_W-1:0] fb_cnt_ref;
    filt_mode_e       det_mode;
    logic             det_lock;

    fb_gray_counter #(.CNT_W(CNT_W)) u_fb_cnt (
        .fb_clk (fb_clk),
        .rst_n  (rst_n),
        .gray_q (fb_gray)
    );

    gray_sync #(.CNT_W(CNT_W)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_in (fb_gray),
        .bin_out (fb_cnt_ref)
    );

    window_judge #(
        .WIN_CYCLES   (WIN_CYCLES),
        .MULT_W       (MULT_W),
        .CNT_W        (CNT_W),
        .ACQ_SHIFT    (ACQ_SHIFT),
        .LOCK_SHIFT   (LOCK_SHIFT),
        .LOCK_WINDOWS (LOCK_WINDOWS)
    ) u_judge (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .mult     (mult),
        .fb_cnt   (fb_cnt_ref),
        .det_mode (det_mode),
        .lock_q   (det_lock)
    );

    lock_event_irq u_evt (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .lock      (det_lock),
        .irq_en    (irq_en),
        .flag_clr  (flag_clr),
        .lock_flag (lock_flag),
        .irq       (irq)
    );

    // Filter mode: detector choice in automatic control, software bit otherwise.
    always_comb begin
        if (auto_en) filt_track = (det_mode == MODE_TRACK);
        else         filt_track = track_sw;
    end

    assign lock     = det_lock;
    assign clk_safe = det_lock & auto_en;

endmodule

// File: tb/tb_pll_lock_detect.sv
// Self-checking bench for pll_lock_detect: a frequency vector table, then
// directed tests for window timing, events, manual mode and reset.
module tb_pll_lock_detect;

    localparam int CLK_PERIOD = 80;
    localparam int WIN        = 64;
    localparam int VEC_N      = 8;
    // Per entry: multiplier, feedback half period, expected lock after settling.
    localparam int V_MULT [VEC_N] = '{4, 4, 2, 2, 2, 5, 5, 8};
    localparam int V_HALF [VEC_N] = '{10, 12, 21, 20, 21, 16, 8, 5};
    localparam int V_LOCK [VEC_N] = '{1, 0, 0, 1, 1, 0, 1, 1};

    logic       ref_clk = 1'b0;
    logic       fb_clk  = 1'b0;
    logic       rst_n   = 1'b0;
    logic       auto_en = 1'b1;
    logic       track_sw = 1'b0;
    logic       irq_en  = 1'b0;
    logic       flag_clr = 1'b0;
    logic [3:0] mult    = 4'd4;
    logic       filt_track, lock, lock_flag, irq, clk_safe;

    int fb_half = 10;
    int n_chk   = 0;
    int n_fail  = 0;

    pll_lock_detect dut (
        .ref_clk    (ref_clk),
        .fb_clk     (fb_clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .track_sw   (track_sw),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .mult       (mult),
        .filt_track (filt_track),
        .lock       (lock),
        .lock_flag  (lock_flag),
        .irq        (irq),
        .clk_safe   (clk_safe)
    );

    initial forever #(CLK_PERIOD / 2) ref_clk = ~ref_clk;
    initial forever #(fb_half) fb_clk = ~fb_clk;

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check, then the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        wait_ref(6);
        check("R1 lock",       lock,       1'b0);
        check("R1 filt_track", filt_track, 1'b0);
        check("R1 lock_flag",  lock_flag,  1'b0);
        check("R1 irq",        irq,        1'b0);
        check("R1 clk_safe",   clk_safe,   1'b0);
        rst_n = 1'b1;

        // Vector table: R3 far off, R4 exact, R5 middle band holds; R10 at fast ratios.
        for (int v = 0; v < VEC_N; v++) begin
            mult    = 4'(V_MULT[v]);
            fb_half = V_HALF[v];
            wait_ref(5 * WIN);
            check($sformatf("R3/R4/R5/R10 vec%0d lock", v), lock, 1'(V_LOCK[v]));
            check($sformatf("R6 vec%0d filt_track", v), filt_track, 1'(V_LOCK[v]));
            check($sformatf("R9 vec%0d clk_safe", v), clk_safe, 1'(V_LOCK[v]));
        end

        // R3: from lock, a far-off frequency drops lock within two windows.
        fb_half = 10;
        wait_ref(140);
        check("R3 lock lost", lock, 1'b0);
        check("R3 acquisition", filt_track, 1'b0);
        wait_ref(WIN);

        // R2/R4: back on frequency, lock needs two full good windows.
        fb_half = 5;
        wait_ref(120);
        check("R2/R4 no lock after one window", lock, 1'b0);
        wait_ref(80);
        check("R2/R4 lock after two windows", lock, 1'b1);

        // R7/R8: flag is set by the changes above, irq masked.
        check("R7 flag sticky", lock_flag, 1'b1);
        check("R8 irq masked", irq, 1'b0);
        flag_clr = 1'b1;
        wait_ref(1);
        flag_clr = 1'b0;
        check("R7 flag cleared", lock_flag, 1'b0);
        wait_ref(2 * WIN);
        check("R7 no change no flag", lock_flag, 1'b0);
        irq_en = 1'b1;
        wait_ref(1);
        check("R8 irq needs flag", irq, 1'b0);
        fb_half = 10;
        wait_ref(3 * WIN);
        check("R7 flag on lock loss", lock_flag, 1'b1);
        check("R8 irq raised", irq, 1'b1);
        flag_clr = 1'b1;
        wait_ref(1);
        flag_clr = 1'b0;
        check("R8 irq cleared", irq, 1'b0);

        // R6/R9: manual mode overrides filter mode, detection continues.
        auto_en  = 1'b0;
        track_sw = 1'b1;
        wait_ref(1);
        check("R6 manual tracking", filt_track, 1'b1);
        check("R9 safe off", clk_safe, 1'b0);
        fb_half = 5;
        wait_ref(4 * WIN);
        check("R6 lock in manual", lock, 1'b1);
        check("R9 safe needs auto", clk_safe, 1'b0);
        track_sw = 1'b0;
        wait_ref(1);
        check("R6 manual acquisition", filt_track, 1'b0);
        auto_en = 1'b1;
        wait_ref(1);
        check("R6 auto tracking", filt_track, 1'b1);
        check("R9 safe on", clk_safe, 1'b1);

        // R1: reset from a locked, flagged state.
        rst_n = 1'b0;
        wait_ref(4);
        check("R1 reset lock",      lock,       1'b0);
        check("R1 reset filt",      filt_track, 1'b0);
        check("R1 reset flag",      lock_flag,  1'b0);
        check("R1 reset irq",       irq,        1'b0);
        check("R1 reset clk_safe",  clk_safe,   1'b0);
        rst_n = 1'b1;
        wait_ref(2);

        finish_run();
    end

endmodule